// File: doc/BRIEF.md
# Stack Arithmetic Unit

This block is an 8-bit arithmetic engine driven like a small stack machine. Values are placed on a last-in-first-out stack that lives in a single-port synchronous memory. Arithmetic opcodes take the two topmost entries and put back one result. The host presents a 3-bit opcode together with an operand for a single clock. The block then runs a short multi-cycle sequence and answers with a one-cycle completion strobe. When the operation is a pop, the popped value is on the result output during that same cycle.

The operand and opcode ports feed flip-flops directly, and the result and completion ports are driven straight from flip-flops. There is no logic on any of these boundary paths. An opcode is sampled only while the sequencer is idle, and each operation has a fixed latency. The stack depth comes from an address-width parameter: the default is 16 entries, and a width of 7 gives 128. Any push, pop or arithmetic request that would overrun or underrun the stack still finishes with a strobe, but it leaves the stack untouched.

Top module: `stack_alu`

## Requirements
- R1: While reset is asserted (rstN low, asynchronous), result reads 0 and done reads 0. The stack starts empty after reset, so a first pop is refused.
- R2: Opcode 000 (idle) and the unused codes 011, 110 and 111 never raise done and do not change the stack or result.
- R3: Opcode 001 pushes the operand value that was present at the clock edge sampling the opcode. Later changes to the operand have no effect. done rises 2 cycles after that sampling edge.
- R4: Opcode 010 removes the top entry and places it on result at the edge where done rises, 3 cycles after the sampling edge. result changes at no other time.
- R5: Opcode 100 removes the two top entries and pushes their sum modulo 256. done rises 4 cycles after the sampling edge.
- R6: Opcode 101 removes the two top entries and pushes the low 8 bits of their unsigned product. done rises 4 cycles after the sampling edge.
- R7: done is high for exactly one cycle per accepted non-idle opcode.
- R8: A push onto a full stack is refused: the stack is unchanged, and done still rises 2 cycles after the sampling edge.
- R9: A pop with an empty stack, or an add or multiply with fewer than two entries, is refused. The stack and result are unchanged, and done rises 2 cycles after the sampling edge.
- R10: While an operation is in progress, the opcode input is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| operand | input | 8 | Value to push |
| opcode | input | 3 | Operation select |
| result | output | 8 | Last popped value |
| done | output | 1 | One-cycle completion strobe |

## Verification
The bench builds the block with an address width of 3, which gives an 8-entry stack. At that size a handful of pushes reaches the full condition and tests the refusal at the boundary. The refused push is followed by a complete drain, which confirms that no entry was overwritten and that pops come back in reverse order. At this width the pointer also reaches both its empty and its full value within a short run.

// File: rtl/stack_alu_pkg.sv
package stack_alu_pkg;
  typedef logic [2:0] opcode_t;
  localparam opcode_t OPC_IDLE = 3'b000;
  localparam opcode_t OPC_PUSH = 3'b001;
  localparam opcode_t OPC_POP  = 3'b010;
  localparam opcode_t OPC_ADD  = 3'b100;
  localparam opcode_t OPC_MUL  = 3'b101;

  // strobes from sequencer to datapath / memory
  typedef struct packed {
    logic latchOperand;
    logic latchFirst;
    logic loadResult;
    logic finish;
    logic memEn;
    logic memWe;
    logic wrAlu;
    logic mulSel;
  } ctrlStrb_t;
endpackage

// File: rtl/stack_alu_sram.sv
module stack_alu_sram #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (en && we) cells[addr] <= wdata;
  end

  // output always driven, registered read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdata <= '0;
    else if (en && !we)   rdata <= cells[addr];
  end
endmodule

// File: rtl/stack_alu_dpath.sv
module stack_alu_dpath
  import stack_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] operandIn,
  input  opcode_t           opcodeIn,
  input  ctrlStrb_t         strb,
  input  logic [DATA_W-1:0] memRdata,
  output opcode_t           opSample,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  logic [DATA_W-1:0] operandReg;
  logic [DATA_W-1:0] holdOperand;
  logic [DATA_W-1:0] firstVal;
  logic [DATA_W-1:0] aluOut;

  // port-facing registers: no logic before or after
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opSample   <= OPC_IDLE;
      operandReg <= '0;
    end else begin
      opSample   <= opcodeIn;
      operandReg <= operandIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdOperand <= '0;
      firstVal    <= '0;
      result      <= '0;
      done        <= 1'b0;
    end else begin
      if (strb.latchOperand) holdOperand <= operandReg;
      if (strb.latchFirst)   firstVal    <= memRdata;
      if (strb.loadResult)   result      <= memRdata;
      done <= strb.finish;
    end
  end

  // results truncate to DATA_W by context width
  always_comb begin
    if (strb.mulSel) aluOut = memRdata * firstVal;
    else             aluOut = memRdata + firstVal;
    memWdata = strb.wrAlu ? aluOut : holdOperand;
  end
endmodule

// File: rtl/stack_alu_ctrl.sv
module stack_alu_ctrl
  import stack_alu_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  opcode_t           opSample,
  output ctrlStrb_t         strb,
  output logic [ADDR_W-1:0] memAddr,
  output logic [ADDR_W:0]   stackLevel,
  output logic              busy
);
  localparam int SP_W  = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH, ST_REJECT, ST_RDTOP, ST_RDNEXT, ST_POPOUT, ST_COMBINE
  } state_e;

  state_e          state, stateNxt;
  logic [SP_W-1:0] sp;
  logic            spUp, spDown;
  logic            isArith, isMul, setArith, setMul, setKind;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    spUp     = 1'b0;
    spDown   = 1'b0;
    setKind  = 1'b0;
    setArith = 1'b0;
    setMul   = 1'b0;
    strb.mulSel = isMul;
    unique case (state)
      ST_IDLE: begin
        unique case (opSample)
          OPC_PUSH: begin
            strb.latchOperand = 1'b1;
            stateNxt = (sp == SP_W'(DEPTH)) ? ST_REJECT : ST_PUSH;
          end
          OPC_POP: begin
            if (sp == '0) stateNxt = ST_REJECT;
            else begin
              spDown = 1'b1;
              setKind = 1'b1;
              stateNxt = ST_RDTOP;
            end
          end
          OPC_ADD, OPC_MUL: begin
            if (sp < SP_W'(2)) stateNxt = ST_REJECT;
            else begin
              spDown = 1'b1;
              setKind = 1'b1;
              setArith = 1'b1;
              setMul = (opSample == OPC_MUL);
              stateNxt = ST_RDTOP;
            end
          end
          default: stateNxt = ST_IDLE;
        endcase
      end
      ST_PUSH: begin
        strb.memEn  = 1'b1;
        strb.memWe  = 1'b1;
        strb.finish = 1'b1;
        spUp = 1'b1;
        stateNxt = ST_IDLE;
      end
      ST_REJECT: begin
        strb.finish = 1'b1;
        stateNxt = ST_IDLE;
      end
      ST_RDTOP: begin
        strb.memEn = 1'b1;
        if (isArith) begin
          spDown = 1'b1;
          stateNxt = ST_RDNEXT;
        end else begin
          stateNxt = ST_POPOUT;
        end
      end
      ST_RDNEXT: begin
        strb.memEn      = 1'b1;
        strb.latchFirst = 1'b1;
        stateNxt = ST_COMBINE;
      end
      ST_POPOUT: begin
        strb.loadResult = 1'b1;
        strb.finish     = 1'b1;
        stateNxt = ST_IDLE;
      end
      ST_COMBINE: begin
        strb.memEn  = 1'b1;
        strb.memWe  = 1'b1;
        strb.wrAlu  = 1'b1;
        strb.finish = 1'b1;
        spUp = 1'b1;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      sp      <= '0;
      isArith <= 1'b0;
      isMul   <= 1'b0;
    end else begin
      state <= stateNxt;
      if (spUp)        sp <= sp + SP_W'(1);
      else if (spDown) sp <= sp - SP_W'(1);
      if (setKind) begin
        isArith <= setArith;
        isMul   <= setMul;
      end
    end
  end

  assign memAddr    = sp[ADDR_W-1:0];
  assign stackLevel = sp;
  assign busy       = (state != ST_IDLE);
endmodule

// File: rtl/stack_alu.sv
module stack_alu
  import stack_alu_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] operand,
  input  logic [2:0]        opcode,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  ctrlStrb_t         strb;
  opcode_t           opSample;
  logic [ADDR_W-1:0] memAddr;
  logic [ADDR_W:0]   stackLevel;
  logic              busy;
  logic [DATA_W-1:0] memWdata, memRdata;

  stack_alu_dpath #(.DATA_W(DATA_W)) dpath_i (
    .clk(clk), .rstN(rstN), .operandIn(operand), .opcodeIn(opcode),
    .strb(strb), .memRdata(memRdata), .opSample(opSample),
    .memWdata(memWdata), .result(result), .done(done)
  );

  stack_alu_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .opSample(opSample), .strb(strb),
    .memAddr(memAddr), .stackLevel(stackLevel), .busy(busy)
  );

  stack_alu_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk(clk), .rstN(rstN), .en(strb.memEn), .we(strb.memWe),
    .addr(memAddr), .wdata(memWdata), .rdata(memRdata)
  );
endmodule

// File: rtl/stack_alu_chk.sv
module stack_alu_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              busy,
  input logic [2:0]        opSample,
  input logic [ADDR_W:0]   stackLevel
);
  localparam int DEPTH = 1 << ADDR_W;

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !(opSample inside {3'b001, 3'b010, 3'b100, 3'b101}))
      |=> (!busy && !done));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rstN)
    int'(stackLevel) <= DEPTH);

  assert_level_step_R9: assert property (@(posedge clk) disable iff (!rstN)
    (int'(stackLevel) - int'($past(stackLevel)) <= 1) &&
    (int'($past(stackLevel)) - int'(stackLevel) <= 1));
endmodule

bind stack_alu stack_alu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .done(done), .result(result), .busy(busy),
  .opSample(opSample), .stackLevel(stackLevel)
);

// File: tb/stack_alu_tb_top.sv
module stack_alu_tb_top;
  localparam int AW    = 3;
  localparam int LIMIT = 1 << AW;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] operand = '0;
  logic [2:0] opcode = '0;
  logic [7:0] result;
  logic       done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] stk[$];
  logic [7:0] modelY = '0;

  always #5 clk = ~clk;

  stack_alu #(.ADDR_W(AW), .DATA_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .operand(operand), .opcode(opcode),
    .result(result), .done(done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL R7 watchdog actual=%0d expected<=20000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // drive one opcode, compare done/result every cycle against the model
  task automatic doOp(input logic [2:0] op, input logic [7:0] b,
                      input bit noise, input string tag);
    int lat = 0;
    bit popped = 0;
    logic [7:0] newY = modelY;
    logic [7:0] a, c;
    int span;
    case (op)
      3'b001: begin
        lat = 2;
        if (stk.size() < LIMIT) stk.push_back(b);
      end
      3'b010: begin
        if (stk.size() == 0) lat = 2;
        else begin lat = 3; popped = 1; newY = stk.pop_back(); end
      end
      3'b100, 3'b101: begin
        if (stk.size() < 2) lat = 2;
        else begin
          lat = 4;
          a = stk.pop_back();
          c = stk.pop_back();
          stk.push_back(op == 3'b100 ? 8'(a + c) : 8'(a * c));
        end
      end
      default: lat = 0;
    endcase
    span = (lat == 0) ? 8 : lat + 1;
    @(negedge clk);
    opcode  = op;
    operand = b;
    @(posedge clk);
    @(negedge clk);
    opcode  = noise ? 3'b001 : 3'b000;
    operand = ~b;
    for (int n = 1; n <= span; n++) begin
      @(posedge clk);
      @(negedge clk);
      if (n == 2) opcode = 3'b000;
      chk({tag, " done"}, done, (n == lat) ? 1 : 0);
      chk({tag, " result"}, result, (popped && n >= lat) ? newY : modelY);
    end
    modelY = newY;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset done", done, 0);
    chk("R1 reset result", result, 0);
    rstN = 1'b1;
    doOp(3'b010, 8'd0, 0, "R1 empty after reset");
    doOp(3'b000, 8'd9, 0, "R2 idle");
    doOp(3'b011, 8'd9, 0, "R2 undef 011");
    doOp(3'b110, 8'd9, 0, "R2 undef 110");
    doOp(3'b111, 8'd9, 0, "R2 undef 111");
    doOp(3'b001, 8'd5, 0, "R3 push");
    doOp(3'b001, 8'd7, 0, "R3 push");
    doOp(3'b100, 8'd0, 0, "R5 add");
    doOp(3'b010, 8'd0, 0, "R4 pop sum");
    doOp(3'b001, 8'd200, 0, "R3 push");
    doOp(3'b001, 8'd100, 0, "R3 push");
    doOp(3'b100, 8'd0, 1, "R10 add busy");
    doOp(3'b010, 8'd0, 0, "R5 wrap sum");
    doOp(3'b001, 8'd20, 0, "R3 push");
    doOp(3'b001, 8'd13, 0, "R3 push");
    doOp(3'b101, 8'd0, 0, "R6 mul");
    doOp(3'b010, 8'd0, 0, "R6 pop prod");
    doOp(3'b001, 8'd255, 0, "R3 push");
    doOp(3'b001, 8'd255, 0, "R3 push");
    doOp(3'b101, 8'd0, 1, "R10 mul busy");
    doOp(3'b101, 8'd0, 0, "R9 mul one entry");
    doOp(3'b100, 8'd0, 0, "R9 add one entry");
    doOp(3'b010, 8'd0, 0, "R6 pop prod wrap");
    doOp(3'b010, 8'd0, 0, "R9 pop empty");
    doOp(3'b000, 8'd0, 0, "R2 idle after reject");
    for (int i = 0; i < LIMIT; i++) doOp(3'b001, 8'(i * 3 + 1), 0, "R3 fill");
    doOp(3'b001, 8'hEE, 0, "R8 push full");
    for (int i = 0; i < LIMIT; i++) doOp(3'b010, 8'd0, 0, "R8 drain");
    doOp(3'b010, 8'd0, 0, "R9 pop drained");
    doOp(3'b100, 8'd0, 0, "R9 add empty");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule